// File: doc/BRIEF.md
# ECC Check-Symbol Packer and Unpacker

This block moves a set of eight 10-bit error-correction check symbols between the form a hardware code generator produces and the dense ten-byte form stored in a flash page's spare area. In the write direction it takes four 32-bit result words, each carrying two symbols in fixed fields, and emits ten bytes on a valid/ready byte stream. In the read direction it takes ten spare-area bytes from a byte stream and, unless the page is blank, recovers the eight symbols and replays them to a decoder load port, highest-numbered symbol first.

The byte image is the eight symbols laid end to end, symbol 0 in the least significant bits, and cut into bytes from the bottom. Read back as five little-endian 16-bit halfwords, the same image yields the symbols again. A page whose ten stored bytes are all 0xFF is blank: no symbols go to the decoder and a one-cycle erased indication is raised instead. Only one transfer runs at a time; the other direction waits with its ready held low.

Top module: `ecc_code_packer`

## Requirements
- R1: Result word k (0..3) supplies symbol 2k from bits 9:0 and symbol 2k+1 from bits 25:16; bits 15:10 and 31:26 have no effect on any output.
- R2: The cycle after the fourth word is accepted, tx_byte_valid rises and ten bytes leave in order n = 0..9, byte n being bits 8n+7:8n of the 80-bit image with symbol j in bits 10j+9:10j (for each pair of words w0,w1: w0[7:0], {w0[21:16],w0[9:8]}, {w1[3:0],w0[25:22]}, {w1[17:16],w1[9:4]}, w1[25:18]).
- R3: While tx_byte_valid is high and tx_byte_ready is low, tx_byte_valid stays high and tx_byte holds its value.
- R4: In the read direction, the ten accepted bytes form halfwords h_i = {byte 2i+1, byte 2i}, and symbol j is bits 10j+9:10j of {h4,h3,h2,h1,h0}.
- R5: After a non-blank tenth byte is accepted, sym_load is high for exactly eight consecutive cycles starting the next cycle, carrying symbol 7 first and symbol 0 last on sym_data.
- R6: load_done is a one-cycle pulse in the cycle right after the cycle that carries symbol 0.
- R7: If all ten read bytes are 0xFF, sym_load and load_done stay low and erased pulses for one cycle in the cycle after the tenth byte is accepted.
- R8: A read image with any byte other than 0xFF, even a single byte, is unpacked and loaded normally.
- R9: From the first accepted word until the last byte leaves, rx_byte_ready is low; from the first accepted read byte until the last symbol is loaded, wr_word_ready, rx-side excluded, and tx_byte_valid are low (wr_word_ready low, tx_byte_valid low).
- R10: wr_word_ready is low while bytes are being emitted, and tx_byte_valid is low while words are being collected.
- R11: During and right after reset, wr_word_ready and rx_byte_ready are high and tx_byte_valid, sym_load, load_done and erased are low.
- R12: When the block is idle and a word and a read byte are offered in the same cycle, the word is taken and rx_byte_ready is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_word_valid | input | 1 | Result word offered |
| wr_word_ready | output | 1 | Result word can be taken |
| wr_word | input | 32 | Result word holding two symbols |
| tx_byte_valid | output | 1 | Packed byte available |
| tx_byte_ready | input | 1 | Downstream takes the packed byte |
| tx_byte | output | 8 | Packed spare-area byte |
| rx_byte_valid | input | 1 | Stored spare-area byte offered |
| rx_byte_ready | output | 1 | Stored byte can be taken |
| rx_byte | input | 8 | Stored spare-area byte |
| sym_load | output | 1 | Symbol strobe to the decoder |
| sym_data | output | 10 | Symbol being loaded |
| load_done | output | 1 | Pulse after the last symbol |
| erased | output | 1 | Pulse when a blank image was read |

## Verification
The bench aims at the field boundaries of the packing: words carrying junk in their masked bits, all-ones and all-zero symbols, and random images, where a wrong slice shows as a single misplaced nibble or pair of bits in one byte or symbol. Blank detection is attacked with a fully blank image and with one where only one bit of one byte is cleared; a design that tested too few bytes would call the second one blank and load nothing. Reverse replay order, the pulse position of load_done and erased, byte hold under random back-pressure, and requests from the other direction arriving mid-transfer or in the same idle cycle are all compared cycle by cycle against a behavioural model, so an off-by-one pulse, a dropped stall or a transfer that slipped in early is caught at the first cycle it differs.

// File: rtl/ecc_pk_pkg.sv
package ecc_pk_pkg;

   typedef enum logic [2:0] {
      PK_IDLE,
      PK_WCOL,
      PK_EMIT,
      PK_RCOL,
      PK_LOAD
   } pk_state_e;

   function automatic int pk_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ecc_pk_ctrl.sv
module ecc_pk_ctrl
   import ecc_pk_pkg::*;
#(
   parameter int NUM_WORDS = 4,
   parameter int NUM_BYTES = 10,
   parameter int NUM_SYM   = 8,
   parameter int CNT_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_word_valid,
   input  logic             tx_byte_ready,
   input  logic             rx_byte_valid,
   input  logic             rx_is_ones,
   output logic             wr_word_ready,
   output logic             tx_byte_valid,
   output logic             rx_byte_ready,
   output logic             word_we,
   output logic             byte_we,
   output logic             sym_load,
   output logic             load_done,
   output logic             erased,
   output logic [CNT_W-1:0] idx
);

   localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(NUM_WORDS - 1);
   localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(NUM_BYTES - 1);
   localparam logic [CNT_W-1:0] LAST_SYM  = CNT_W'(NUM_SYM - 1);

   pk_state_e        st_q;
   logic [CNT_W-1:0] idx_q;
   logic             ones_q;
   logic             done_q;
   logic             erased_q;
   logic             idle;

   always_comb begin
      idle          = (st_q == PK_IDLE);
      wr_word_ready = idle || (st_q == PK_WCOL);
      rx_byte_ready = (idle && !wr_word_valid) || (st_q == PK_RCOL);
      word_we       = wr_word_valid && wr_word_ready;
      byte_we       = rx_byte_valid && rx_byte_ready;
      tx_byte_valid = (st_q == PK_EMIT);
      sym_load      = (st_q == PK_LOAD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PK_IDLE;
         idx_q    <= '0;
         ones_q   <= 1'b0;
         done_q   <= 1'b0;
         erased_q <= 1'b0;
      end else begin
         done_q   <= 1'b0;
         erased_q <= 1'b0;
         unique case (st_q)
            PK_IDLE: begin
               if (word_we) begin
                  st_q  <= PK_WCOL;
                  idx_q <= CNT_W'(1);
               end else if (byte_we) begin
                  st_q   <= PK_RCOL;
                  idx_q  <= CNT_W'(1);
                  ones_q <= rx_is_ones;
               end
            end
            PK_WCOL: begin
               if (word_we) begin
                  if (idx_q == LAST_WORD) begin
                     st_q  <= PK_EMIT;
                     idx_q <= '0;
                  end else begin
                     idx_q <= idx_q + CNT_W'(1);
                  end
               end
            end
            PK_EMIT: begin
               if (tx_byte_ready) begin
                  if (idx_q == LAST_BYTE) begin
                     st_q  <= PK_IDLE;
                     idx_q <= '0;
                  end else begin
                     idx_q <= idx_q + CNT_W'(1);
                  end
               end
            end
            PK_RCOL: begin
               if (byte_we) begin
                  if (idx_q == LAST_BYTE) begin
                     if (ones_q && rx_is_ones) begin
                        st_q     <= PK_IDLE;
                        idx_q    <= '0;
                        erased_q <= 1'b1;
                     end else begin
                        st_q  <= PK_LOAD;
                        idx_q <= LAST_SYM;
                     end
                  end else begin
                     idx_q  <= idx_q + CNT_W'(1);
                     ones_q <= ones_q && rx_is_ones;
                  end
               end
            end
            PK_LOAD: begin
               if (idx_q == '0) begin
                  st_q   <= PK_IDLE;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q - CNT_W'(1);
               end
            end
            default: st_q <= PK_IDLE;
         endcase
      end
   end

   assign idx       = idx_q;
   assign load_done = done_q;
   assign erased    = erased_q;

endmodule

// File: rtl/ecc_pk_image.sv
module ecc_pk_image #(
   parameter int SYM_W   = 10,
   parameter int NUM_SYM = 8,
   parameter int WORD_W  = 32,
   parameter int HI_LSB  = 16,
   parameter int BYTE_W  = 8,
   parameter int CNT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_we,
   input  logic              byte_we,
   input  logic [CNT_W-1:0]  idx,
   input  logic [WORD_W-1:0] word_in,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              byte_in_ones,
   output logic [BYTE_W-1:0] byte_out,
   output logic [SYM_W-1:0]  sym_out
);

   localparam int IMG_W     = SYM_W * NUM_SYM;
   localparam int NUM_BYTES = IMG_W / BYTE_W;
   localparam int NUM_WORDS = NUM_SYM / 2;

   logic [IMG_W-1:0]  img_q;
   logic [IMG_W-1:0]  img_d;
   logic [SYM_W-1:0]  lo_field;
   logic [SYM_W-1:0]  hi_field;
   logic [BYTE_W-1:0] byte_arr [NUM_BYTES];
   logic [SYM_W-1:0]  sym_arr  [NUM_SYM];
   logic              unused_word_bits;

   assign lo_field         = word_in[SYM_W-1:0];
   assign hi_field         = word_in[HI_LSB +: SYM_W];
   assign unused_word_bits = ^word_in;
   assign byte_in_ones     = &byte_in;

   always_comb begin
      img_d = img_q;
      if (word_we) begin
         for (int k = 0; k < NUM_WORDS; k++) begin
            if (idx == CNT_W'(k)) begin
               img_d[(2*k)*SYM_W +: SYM_W]   = lo_field;
               img_d[(2*k+1)*SYM_W +: SYM_W] = hi_field;
            end
         end
      end
      if (byte_we) begin
         for (int b = 0; b < NUM_BYTES; b++) begin
            if (idx == CNT_W'(b)) begin
               img_d[b*BYTE_W +: BYTE_W] = byte_in;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         img_q <= '0;
      end else begin
         img_q <= img_d;
      end
   end

   for (genvar gb = 0; gb < NUM_BYTES; gb++) begin : g_byte
      assign byte_arr[gb] = img_q[gb*BYTE_W +: BYTE_W];
   end

   for (genvar gs = 0; gs < NUM_SYM; gs++) begin : g_sym
      assign sym_arr[gs] = img_q[gs*SYM_W +: SYM_W];
   end

   always_comb begin
      byte_out = '0;
      for (int b = 0; b < NUM_BYTES; b++) begin
         if (idx == CNT_W'(b)) byte_out = byte_arr[b];
      end
   end

   always_comb begin
      sym_out = '0;
      for (int s = 0; s < NUM_SYM; s++) begin
         if (idx == CNT_W'(s)) sym_out = sym_arr[s];
      end
   end

endmodule

// File: rtl/ecc_code_packer.sv
module ecc_code_packer
   import ecc_pk_pkg::*;
#(
   parameter int SYM_W   = 10,
   parameter int NUM_SYM = 8,
   parameter int WORD_W  = 32,
   parameter int HI_LSB  = 16,
   parameter int BYTE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_word_valid,
   output logic              wr_word_ready,
   input  logic [WORD_W-1:0] wr_word,
   output logic              tx_byte_valid,
   input  logic              tx_byte_ready,
   output logic [BYTE_W-1:0] tx_byte,
   input  logic              rx_byte_valid,
   output logic              rx_byte_ready,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic              sym_load,
   output logic [SYM_W-1:0]  sym_data,
   output logic              load_done,
   output logic              erased
);

   localparam int IMG_W     = SYM_W * NUM_SYM;
   localparam int NUM_BYTES = IMG_W / BYTE_W;
   localparam int NUM_WORDS = NUM_SYM / 2;
   localparam int MAX_IDX   = pk_max(NUM_BYTES, NUM_SYM) - 1;
   localparam int CNT_W     = $clog2(MAX_IDX + 1);

   if (IMG_W % BYTE_W != 0) begin : g_bad_img
      $error("symbol image must be a whole number of bytes");
   end
   if (NUM_SYM % 2 != 0 || NUM_SYM < 4) begin : g_bad_nsym
      $error("symbol count must be even and at least four");
   end
   if (HI_LSB < SYM_W || HI_LSB + SYM_W > WORD_W) begin : g_bad_field
      $error("upper symbol field must sit above the lower one inside the word");
   end

   logic             word_we;
   logic             byte_we;
   logic             rx_is_ones;
   logic [CNT_W-1:0] idx;

   ecc_pk_ctrl #(
      .NUM_WORDS (NUM_WORDS),
      .NUM_BYTES (NUM_BYTES),
      .NUM_SYM   (NUM_SYM),
      .CNT_W     (CNT_W)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_word_valid (wr_word_valid),
      .tx_byte_ready (tx_byte_ready),
      .rx_byte_valid (rx_byte_valid),
      .rx_is_ones    (rx_is_ones),
      .wr_word_ready (wr_word_ready),
      .tx_byte_valid (tx_byte_valid),
      .rx_byte_ready (rx_byte_ready),
      .word_we       (word_we),
      .byte_we       (byte_we),
      .sym_load      (sym_load),
      .load_done     (load_done),
      .erased        (erased),
      .idx           (idx)
   );

   ecc_pk_image #(
      .SYM_W   (SYM_W),
      .NUM_SYM (NUM_SYM),
      .WORD_W  (WORD_W),
      .HI_LSB  (HI_LSB),
      .BYTE_W  (BYTE_W),
      .CNT_W   (CNT_W)
   ) u_image (
      .clk          (clk),
      .rst_n        (rst_n),
      .word_we      (word_we),
      .byte_we      (byte_we),
      .idx          (idx),
      .word_in      (wr_word),
      .byte_in      (rx_byte),
      .byte_in_ones (rx_is_ones),
      .byte_out     (tx_byte),
      .sym_out      (sym_data)
   );

endmodule

// File: rtl/ecc_code_packer_chk.sv
module ecc_code_packer_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_word_valid,
   input logic              wr_word_ready,
   input logic              tx_byte_valid,
   input logic              tx_byte_ready,
   input logic [BYTE_W-1:0] tx_byte,
   input logic              rx_byte_ready,
   input logic              sym_load,
   input logic              load_done,
   input logic              erased
);

   p_write_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_byte_valid |-> (!rx_byte_ready && !wr_word_ready));

   p_read_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sym_load |-> (!wr_word_ready && !rx_byte_ready && !tx_byte_valid));

   p_byte_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_byte_valid && !tx_byte_ready) |=> (tx_byte_valid && $stable(tx_byte)));

   p_done_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |-> ($past(sym_load) && !sym_load));

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      load_done |=> !load_done);

   p_erased_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      erased |-> (!sym_load && !load_done && !$past(sym_load)));

   p_load_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sym_load) |=> sym_load);

   p_tie_to_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_word_valid && wr_word_ready) |-> !rx_byte_ready);

endmodule

bind ecc_code_packer ecc_code_packer_chk #(
   .BYTE_W (BYTE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_word_valid (wr_word_valid),
   .wr_word_ready (wr_word_ready),
   .tx_byte_valid (tx_byte_valid),
   .tx_byte_ready (tx_byte_ready),
   .tx_byte       (tx_byte),
   .rx_byte_ready (rx_byte_ready),
   .sym_load      (sym_load),
   .load_done     (load_done),
   .erased        (erased)
);

// File: tb/test_ecc_code_packer.sv
`timescale 1ns/1ps
module test_ecc_code_packer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_word_valid = 1'b0;
   logic        wr_word_ready;
   logic [31:0] wr_word = '0;
   logic        tx_byte_valid;
   logic        tx_byte_ready = 1'b1;
   logic [7:0]  tx_byte;
   logic        rx_byte_valid = 1'b0;
   logic        rx_byte_ready;
   logic [7:0]  rx_byte = '0;
   logic        sym_load;
   logic [9:0]  sym_data;
   logic        load_done;
   logic        erased;

   int check_cnt = 0;
   int fail_cnt  = 0;
   bit started   = 1'b0;
   bit stall     = 1'b0;

   always #2 clk = ~clk;

   ecc_code_packer i_ecc_code_packer (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_word_valid (wr_word_valid),
      .wr_word_ready (wr_word_ready),
      .wr_word       (wr_word),
      .tx_byte_valid (tx_byte_valid),
      .tx_byte_ready (tx_byte_ready),
      .tx_byte       (tx_byte),
      .rx_byte_valid (rx_byte_valid),
      .rx_byte_ready (rx_byte_ready),
      .rx_byte       (rx_byte),
      .sym_load      (sym_load),
      .sym_data      (sym_data),
      .load_done     (load_done),
      .erased        (erased)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      check_cnt++;
      if (!ok) begin
         fail_cnt++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // behavioural model state
   logic [7:0]  txq[$];
   logic [9:0]  symq[$];
   logic [31:0] wbuf [4];
   logic [7:0]  rbuf [10];
   int  words_n = 0;
   int  bytes_n = 0;
   int  sym_left = 0;
   bit  done_exp = 1'b0;
   bit  erased_exp = 1'b0;

   task automatic model_pack();
      for (int p = 0; p < 2; p++) begin
         logic [31:0] a, c;
         a = wbuf[2*p];
         c = wbuf[2*p+1];
         txq.push_back(a[7:0]);
         txq.push_back({a[21:16], a[9:8]});
         txq.push_back({c[3:0], a[25:22]});
         txq.push_back({c[17:16], c[9:4]});
         txq.push_back(c[25:18]);
      end
   endtask

   task automatic model_unpack();
      logic [15:0] h [5];
      logic [9:0]  s [8];
      bit all_ones;
      all_ones = 1'b1;
      for (int i = 0; i < 10; i++) if (rbuf[i] != 8'hFF) all_ones = 1'b0;
      for (int i = 0; i < 5; i++) h[i] = {rbuf[2*i+1], rbuf[2*i]};
      if (all_ones) begin
         erased_exp = 1'b1;
      end else begin
         s[0] = h[0][9:0];
         s[1] = {h[1][3:0], h[0][15:10]};
         s[2] = h[1][13:4];
         s[3] = {h[2][7:0], h[1][15:14]};
         s[4] = {h[3][1:0], h[2][15:8]};
         s[5] = h[3][11:2];
         s[6] = {h[4][5:0], h[3][15:12]};
         s[7] = h[4][15:6];
         for (int j = 7; j >= 0; j--) symq.push_back(s[j]);
         sym_left = 8;
      end
   endtask

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      if (rst_n && started) begin
         bit busy;
         bit rd_busy;
         busy    = (words_n > 0) || (txq.size() > 0) || (bytes_n > 0) || (sym_left > 0);
         rd_busy = (bytes_n > 0) || (sym_left > 0);
         chk(wr_word_ready == !(rd_busy || txq.size() > 0), (rd_busy ? "R9" : "R10"),
             "wr_word_ready", wr_word_ready, !(rd_busy || txq.size() > 0));
         chk(rx_byte_ready == ((bytes_n > 0) || (!busy && !wr_word_valid)),
             ((!busy && wr_word_valid) ? "R12" : "R9"), "rx_byte_ready",
             rx_byte_ready, (bytes_n > 0) || (!busy && !wr_word_valid));
         chk(tx_byte_valid == (txq.size() > 0), "R10", "tx_byte_valid",
             tx_byte_valid, txq.size() > 0);
         if (tx_byte_valid && txq.size() > 0)
            chk(tx_byte == txq[0], "R2", "tx_byte", tx_byte, txq[0]);
         chk(sym_load == (sym_left > 0), "R5", "sym_load", sym_load, sym_left > 0);
         if (sym_load && sym_left > 0)
            chk(sym_data == symq[0], "R4", "sym_data", sym_data, symq[0]);
         chk(load_done == done_exp, "R6", "load_done", load_done, done_exp);
         chk(erased == erased_exp, "R7", "erased", erased, erased_exp);

         done_exp   = 1'b0;
         erased_exp = 1'b0;
         if (tx_byte_valid && tx_byte_ready && txq.size() > 0) void'(txq.pop_front());
         if (sym_load && sym_left > 0) begin
            void'(symq.pop_front());
            sym_left--;
            if (sym_left == 0) done_exp = 1'b1;
         end
         if (wr_word_valid && wr_word_ready) begin
            wbuf[words_n] = wr_word;
            words_n++;
            if (words_n == 4) begin
               model_pack();
               words_n = 0;
            end
         end
         if (rx_byte_valid && rx_byte_ready) begin
            rbuf[bytes_n] = rx_byte;
            bytes_n++;
            if (bytes_n == 10) begin
               model_unpack();
               bytes_n = 0;
            end
         end
      end
   end

   always @(posedge clk) begin
      #1 tx_byte_ready = stall ? ($urandom_range(0, 2) != 0) : 1'b1;
   end

   task automatic put_words(input logic [127:0] ws);
      @(posedge clk); #1;
      for (int k = 0; k < 4; k++) begin
         wr_word_valid = 1'b1;
         wr_word       = ws[32*k +: 32];
         @(negedge clk);
         while (!wr_word_ready) @(negedge clk);
         @(posedge clk); #1;
      end
      wr_word_valid = 1'b0;
   endtask

   task automatic put_bytes(input logic [79:0] img);
      @(posedge clk); #1;
      for (int n = 0; n < 10; n++) begin
         rx_byte_valid = 1'b1;
         rx_byte       = img[8*n +: 8];
         @(negedge clk);
         while (!rx_byte_ready) @(negedge clk);
         @(posedge clk); #1;
      end
      rx_byte_valid = 1'b0;
   endtask

   task automatic wait_idle();
      repeat (2) @(posedge clk);
      while (words_n > 0 || txq.size() > 0 || bytes_n > 0 || sym_left > 0)
         @(posedge clk);
      repeat (3) @(posedge clk);
   endtask

   function automatic logic [127:0] rand_words();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   function automatic logic [79:0] rand_img();
      return {16'($urandom), $urandom, $urandom};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fail_cnt++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", check_cnt, fail_cnt);
      $finish;
   end

   initial begin
      // R11: outputs during reset
      repeat (3) @(negedge clk);
      chk(wr_word_ready == 1'b1, "R11", "wr_word_ready in reset", wr_word_ready, 1);
      chk(rx_byte_ready == 1'b1, "R11", "rx_byte_ready in reset", rx_byte_ready, 1);
      chk(tx_byte_valid == 1'b0, "R11", "tx_byte_valid in reset", tx_byte_valid, 0);
      chk(sym_load == 1'b0, "R11", "sym_load in reset", sym_load, 0);
      chk(load_done == 1'b0 && erased == 1'b0, "R11", "pulses in reset",
          {load_done, erased}, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      started = 1'b1;
      repeat (2) @(posedge clk);

      // R1: only masked bits set -> all-zero bytes; all-ones fields -> 0xFF bytes
      put_words({4{32'hFC00_FC00}});
      wait_idle();
      put_words({4{32'h03FF_03FF}});
      wait_idle();
      // R2: random words with junk in masked bits
      for (int t = 0; t < 6; t++) begin
         put_words(rand_words());
         wait_idle();
      end
      // R3: back-pressure on the byte stream
      stall = 1'b1;
      for (int t = 0; t < 6; t++) begin
         put_words(rand_words());
         wait_idle();
      end
      stall = 1'b0;

      // R4/R5/R6: random images
      for (int t = 0; t < 8; t++) begin
         put_bytes(rand_img());
         wait_idle();
      end
      put_bytes('0);
      wait_idle();
      // R7: blank image
      put_bytes({10{8'hFF}});
      wait_idle();
      // R8: one bit cleared in a single byte
      put_bytes({{5{8'hFF}}, 8'hFE, {4{8'hFF}}});
      wait_idle();
      put_bytes({8'h7F, {9{8'hFF}}});
      wait_idle();
      put_bytes({{9{8'hFF}}, 8'hFE});
      wait_idle();

      // R12: word and byte offered together in idle
      fork
         put_words(rand_words());
         put_bytes(rand_img());
      join
      wait_idle();
      // R9: read arriving during a write
      stall = 1'b1;
      fork
         put_words(rand_words());
         begin repeat (6) @(posedge clk); put_bytes(rand_img()); end
      join
      wait_idle();
      // R9: write arriving during a read
      fork
         put_bytes(rand_img());
         begin repeat (11) @(posedge clk); put_words(rand_words()); end
      join
      wait_idle();
      // back-to-back blank and non-blank reads, then a write
      fork
         begin put_bytes({10{8'hFF}}); put_bytes(rand_img()); end
         begin repeat (4) @(posedge clk); put_words(rand_words()); end
      join
      wait_idle();
      stall = 1'b0;

      chk(txq.size() == 0 && symq.size() == 0, "R2", "model drained",
          txq.size() + symq.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", check_cnt, fail_cnt);
      $finish;
   end

endmodule